// File: doc/BRIEF.md
# Change-of-Flow Trace Address Buffer

This block keeps a short history of where program flow went. Whenever the fetch logic reports a taken discontinuity (a taken branch, entry into or return from an exception handler, or a pipeline refill forced by a context-synchronising instruction), it raises a capture strobe together with the 32-bit destination address. The block stores that address in a small ring of entries. Ordinary sequential fetches are never reported and never stored.

An external debug controller reads the history back through one register location. There is no per-entry address. Each read access returns the entry under a shared wrap-around index and then advances that index, so repeated reads walk through the ring. Captures use the same index, which means that after any capture the index points at the oldest entry. A freeze input, typically held while the core sits in debug mode, blocks new captures so that they cannot disturb a readout.

Top module: `cof_trace_buf`

## Requirements
- R1: A capture strobe with freeze low writes the capture address into the entry selected by the shared index, then advances the index by one. When the capture strobe is low, nothing is written.
- R2: The shared 3-bit index counts 0,1,...,7 and then returns to 0. Both captures and reads advance it.
- R3: A read access is a read strobe with the register select high. A read strobe with the select low has no effect: the index does not move and the read data does not change.
- R4: A read access returns the entry at the current index and advances the index by one.
- R5: After at least eight captures, eight reads return the last eight captured addresses from oldest to newest and leave the index where it started, so the next eight reads return the same sequence again.
- R6: While freeze is high, capture strobes are ignored. No entry changes and the index does not move.
- R7: When a capture and a read access fall in the same cycle, the read returns the content that slot held before the capture, the capture overwrites that slot, and the index advances by one in total.
- R8: Read data is registered. It shows the selected entry in the cycle after the read access and holds its value in every cycle without a read access.
- R9: Synchronous reset clears the index to 0, all eight entries to 0 and the read data to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Taken change-of-flow capture strobe |
| cap_addr | input | 32 | Destination address to record |
| freeze | input | 1 | Blocks captures when high |
| rd_sel | input | 1 | Selects the trace register |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |

## Verification
The bench drives more than eight captures so that the index wraps, then checks that a full readout comes back in oldest-to-newest order and that a second readout repeats it. A design that advanced the index by two in a cycle with both a capture and a read would skip an entry, and one that read after writing would return the new address. The bench also covers frozen captures and strobes with the select low, where a faulty design would change an entry or move the index. A readout straight after reset must return all zeros.

// File: rtl/cof_pkg.sv
`timescale 1ns/1ps
package cof_pkg;
  // Wrap-around increment used by the shared ring index
  function automatic int unsigned ring_inc(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/cof_ring_index.sv
`timescale 1ns/1ps
module cof_ring_index #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)
      idx <= '0;
    else if (step)
      idx <= IW'(cof_pkg::ring_inc(int'(idx), DEPTH));
  end

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (step && idx == LAST) |=> (idx == '0));
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx));
endmodule

// File: rtl/cof_entry_store.sv
`timescale 1ns/1ps
module cof_entry_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] slot,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] slot_word
);
  logic [AW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= '0;
      else if (we && slot == IW'(g))
        ent[g] <= wdata;
    end
  end

  // Old content of the selected slot; a same-cycle write lands after the edge
  assign slot_word = ent[slot];

  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (ent[$past(slot)] == $past(wdata)));
endmodule

// File: rtl/cof_read_port.sv
`timescale 1ns/1ps
module cof_read_port #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] word,
  output logic [AW-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (rd_en)
      rd_q <= word;
  end

  a_r8_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/cof_trace_buf.sv
`timescale 1ns/1ps
module cof_trace_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_valid,
  input  logic [AW-1:0] cap_addr,
  input  logic          freeze,
  input  logic          rd_sel,
  input  logic          rd_stb,
  output logic [AW-1:0] rd_data
);
  logic          cap_en;
  logic          rd_en;
  logic [IW-1:0] idx;
  logic [AW-1:0] cur_word;

  assign cap_en = cap_valid && !freeze;
  assign rd_en  = rd_stb && rd_sel;

  // One step per cycle even when a capture and a read coincide
  cof_ring_index #(.DEPTH(DEPTH)) u_idx (
    .clk (clk), .rst (rst), .step (cap_en || rd_en), .idx (idx)
  );

  cof_entry_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk (clk), .rst (rst), .we (cap_en), .slot (idx),
    .wdata (cap_addr), .slot_word (cur_word)
  );

  cof_read_port #(.AW(AW)) u_rd (
    .clk (clk), .rst (rst), .rd_en (rd_en), .word (cur_word), .rd_q (rd_data)
  );

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (idx == '0 && rd_data == '0));
  a_r6_freeze_blocks: assert property (@(posedge clk) disable iff (rst)
    (freeze && !rd_en) |=> $stable(idx));
  a_r3_unselected_strobe: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_sel && !cap_en) |=> ($stable(idx) && $stable(rd_data)));
endmodule

// File: tb/test_cof_trace_buf.sv
`timescale 1ns/1ps
module test_cof_trace_buf;
  logic        clk = 0;
  logic        rst = 1;
  logic        cap_valid = 0;
  logic [31:0] cap_addr = '0;
  logic        freeze = 0;
  logic        rd_sel = 0;
  logic        rd_stb = 0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m [8];
  int unsigned midx = 0;
  logic [31:0] last_rd = '0;

  always #5 clk = ~clk;

  cof_trace_buf i_cof_trace_buf (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .freeze(freeze), .rd_sel(rd_sel), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  function automatic int unsigned nxt(input int unsigned i);
    return (i == 7) ? 0 : i + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at the edge, sample 1 ns later
  task automatic step(input bit cv, input logic [31:0] a, input bit fz,
                      input bit sel, input bit stb, input string req);
    bit rd, cp;
    logic [31:0] exp;
    @(negedge clk);
    cap_valid = cv; cap_addr = a; freeze = fz; rd_sel = sel; rd_stb = stb;
    @(posedge clk);
    rd = sel && stb;
    cp = cv && !fz;
    exp = rd ? m[midx] : last_rd;
    if (cp) m[midx] = a;
    if (rd || cp) midx = nxt(midx);
    #1;
    chk(req, rd_data, exp);
    last_rd = exp;
    @(negedge clk);
    cap_valid = 0; rd_sel = 0; rd_stb = 0; freeze = 0;
  endtask

  task automatic cap(input logic [31:0] a, input string req);
    step(1, a, 0, 0, 0, req);
  endtask

  task automatic rd(input string req);
    step(0, '0, 0, 1, 1, req);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 chk("R9 reset rd_data", rd_data, 32'h0);
    // R9: all entries read back zero, index returns to 0 (R2)
    for (int i = 0; i < 8; i++) rd("R9 reset entries");
    // R1/R2: ten captures wrap the index
    for (int i = 0; i < 10; i++) cap(32'h1000_0000 + 32'(i * 4), "R1 capture");
    // R5: oldest to newest, twice
    for (int i = 0; i < 16; i++) rd("R5 ordered readout");
    // R6: frozen captures leave entries unchanged
    for (int i = 0; i < 5; i++) step(1, 32'hDEAD_0000 + 32'(i), 1, 0, 0, "R6 freeze");
    for (int i = 0; i < 8; i++) rd("R6 freeze readout");
    // R3: strobe without select
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 1, "R3 unselected strobe");
    rd("R3 next read");
    // R3: select without strobe
    step(0, '0, 0, 1, 0, "R3 select only");
    // R7: capture and read in the same cycle
    step(1, 32'hCAFE_0001, 0, 1, 1, "R7 same-cycle");
    step(1, 32'hCAFE_0002, 0, 1, 1, "R7 same-cycle");
    for (int i = 0; i < 8; i++) rd("R7 readout");
    // R8: idle cycles hold read data
    for (int i = 0; i < 4; i++) step(0, '0, 0, 0, 0, "R8 hold");
    // Random mix covering R1..R8
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 2) == 1, $urandom, ($urandom % 4) == 0,
           ($urandom % 4) != 0, ($urandom % 2) == 1, "R4 random");
    end
    for (int i = 0; i < 8; i++) rd("R5 final readout");
    // R9: reset in mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 8; i++) m[i] = '0;
    midx = 0; last_rd = '0;
    #1 chk("R9 second reset", rd_data, 32'h0);
    for (int i = 0; i < 8; i++) rd("R9 cleared entries");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule